// File: doc/BRIEF.md
# Trace flush and trigger event controller

This block sits beside a trace capture buffer and decides when the buffer must flush, when the formatter must place a trigger marker in the trace stream, and when capture must stop. It takes requests from five places: a self-clearing manual bit in its control word, an external flush pin, an external trigger pin, an internal trigger-event pulse and the completion of a flush. It turns them into one flush request/acknowledge handshake, a marker request toward the formatter, a sticky formatter-stop output and a ready status.

Flushes never overlap. A request that arrives while a flush is outstanding is held in a per-source pending flag and is served in fixed priority once the current flush has been acknowledged. A flush started by the downstream output side runs like any other, but its completion never stops capture and never produces a marker. The two external pins are asynchronous and pass through a two-flop synchronizer before their rising edges are detected.

Top module: `trace_evt_ctrl`

## Requirements
- R1: At most one flush is outstanding. `flush_req` stays high until the cycle `flush_ack` is seen, drops for at least one cycle, and pending requests are then served in the priority manual, external pin, trigger event, downstream.
- R2: Writing `cfg_wdata[4]`=1 with `capture_en` high sets the manual flush bit, which starts one flush and clears itself when that flush completes. The write is ignored while `capture_en` is low. The bit is zero after reset.
- R3: With `cfg_wdata[2]` (flush on pin) set and `fmt_stop` low, a rising edge on `ext_flush_in`, seen after two synchronizer flops, raises a flush request. While `fmt_stop` is high the edge is ignored.
- R4: With `cfg_wdata[3]` (flush on trigger event) set, a `trig_evt` pulse raises a flush request, unless `cfg_wdata[9]` (stop on trigger event) is also set.
- R5: With `cfg_wdata[8]` (stop on flush) set, completion of a flush not started downstream raises `fmt_stop`, but only once every owed marker, including the one for that flush, has been acknowledged.
- R6: With `cfg_wdata[9]` set, a `trig_evt` pulse raises `fmt_stop` on the next clock edge.
- R7: The marker is a single byte 0x00 on `mark_data` with trace ID 0x7D on `mark_id`. `mark_req` stays high while any marker is owed, and each `mark_ack` retires one.
- R8: Markers are owed on flush completion (`cfg_wdata[5]`), on `trig_evt` (`cfg_wdata[6]`) and on a synchronized rising edge of `ext_trig_in` (`cfg_wdata[7]`). Several may be owed at once, up to 7. All three are ignored while both `cfg_wdata[0]` (formatting) and `cfg_wdata[1]` (marker enable) are clear.
- R9: Completion of a flush started by `ds_flush_req` produces neither a marker nor a stop, whatever bits 5 and 8 hold.
- R10: `fmt_on` is high when formatting or the marker enable is set. The marker enable bit takes a new value only from a write made while `ready` is high and `capture_en` is low.
- R11: `fmt_stop` stays high until `capture_en` rises. `ready` falls together with `fmt_stop` and rises again only after `stop_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_en | input | 1 | Trace capture enabled |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word write data |
| ext_flush_in | input | 1 | Asynchronous external flush pin |
| ext_trig_in | input | 1 | Asynchronous external trigger pin |
| trig_evt | input | 1 | Internal trigger event pulse |
| ds_flush_req | input | 1 | Flush request pulse from the downstream side |
| flush_req | output | 1 | Flush in progress |
| flush_ack | input | 1 | Flush complete pulse |
| mark_req | output | 1 | Trigger marker owed to the formatter |
| mark_ack | input | 1 | Formatter accepted one marker |
| mark_data | output | 8 | Marker data byte |
| mark_id | output | 7 | Marker trace ID |
| fmt_stop | output | 1 | Formatter stop, sticky |
| stop_ack | input | 1 | Formatter confirms the stop |
| ready | output | 1 | No stop awaiting confirmation |
| fmt_on | output | 1 | Formatting effectively enabled |

## Verification
The bench drives manual, pin, trigger-event and downstream flush requests in the same cycle. A design without pending flags would lose all but one of them and show fewer than four flushes. It holds off marker acknowledgement after a stop-on-flush completion, and a design that stopped straight after the acknowledge would raise `fmt_stop` while a marker is still owed. It also checks that a downstream flush leaves stop and markers untouched, that the manual bit and the marker enable ignore writes in the wrong state, and that the stop survives until capture is re-enabled. A reference model predicts every output on every cycle, so an off-by-one in the synchronizer or the arbiter shows up as a mismatch at once.

// File: rtl/tev_pkg.sv
// Shared constants and types for the trace event controller.
package tev_pkg;
    localparam int CFG_W  = 10;
    // Control word bit positions (software visible layout).
    localparam int B_FMT  = 0;
    localparam int B_MEN  = 1;
    localparam int B_FEXT = 2;
    localparam int B_FTEV = 3;
    localparam int B_MAN  = 4;
    localparam int B_MFL  = 5;
    localparam int B_MTEV = 6;
    localparam int B_MTRG = 7;
    localparam int B_SFL  = 8;
    localparam int B_STEV = 9;

    localparam int NSRC  = 4;
    localparam int SRC_W = $clog2(NSRC);

    // Flush sources; lower value wins arbitration.
    typedef enum logic [SRC_W-1:0] {
        SRC_MAN  = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_TEVT = 2'd2,
        SRC_DS   = 2'd3
    } fsrc_e;

    localparam logic [7:0] MARK_BYTE = 8'h00;
    localparam logic [6:0] MARK_TID  = 7'h7D;

    // Stored control bits (the manual flush bit is held separately).
    typedef struct packed {
        logic stop_tev;
        logic stop_fl;
        logic mk_trg;
        logic mk_tev;
        logic mk_fl;
        logic fl_tev;
        logic fl_ext;
        logic mk_en;
        logic fmt_en;
    } cfg_t;
endpackage

// File: rtl/tev_edge_sync.sv
// Synchronizes an asynchronous pin through STAGES flops and flags its
// rising edge for one cycle. Assumes the pin is held for more than one cycle.
module tev_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh;

    // Shift the pin in; the extra flop keeps the previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tev_flush_sched.sv
// Serializes flush requests from several sources onto one req/ack
// handshake. Source 0 is a level request that its owner clears; the others
// are pulses latched in pending flags. Assumes flush_ack is a pulse.
module tev_flush_sched
    import tev_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            man_lvl,
    input  logic [NSRC-1:1] set_pulse,
    input  logic            flush_ack,
    output logic            flush_req,
    output logic            done,
    output fsrc_e           act_src
);
    logic [NSRC-1:1] pend;
    logic [NSRC-1:1] clr;
    logic [NSRC-1:0] req_vec;
    logic            any_req;
    logic            grant;
    fsrc_e           pick;

    assign req_vec = {pend, man_lvl};
    assign done    = flush_req && flush_ack;
    assign grant   = !flush_req && any_req;

    // Fixed-priority pick: lowest numbered requesting source.
    always_comb begin
        any_req = 1'b0;
        pick    = SRC_MAN;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                any_req = 1'b1;
                pick    = fsrc_e'(SRC_W'(i));
            end
        end
    end

    generate
        for (genvar g = 1; g < NSRC; g++) begin : g_clr
            assign clr[g] = grant && (pick == fsrc_e'(SRC_W'(g)));
        end
    endgenerate

    // Pending flags: a new pulse wins over the clear of a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | set_pulse;
    end

    // Active flush and its source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_req <= 1'b0;
            act_src   <= SRC_MAN;
        end else if (grant) begin
            flush_req <= 1'b1;
            act_src   <= pick;
        end else if (done) begin
            flush_req <= 1'b0;
        end
    end

    // R1
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_ack |=> flush_req);
    // R1
    src_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_ack |=> $stable(act_src));
    // R1
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !flush_req);
endmodule

// File: rtl/tev_mark_cnt.sv
// Counts trigger markers owed to the formatter, up to three new ones per
// cycle, saturating at the counter maximum. One marker retires per ack.
module tev_mark_cnt #(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] inc,
    input  logic       mark_ack,
    output logic       mark_req
);
    localparam int MAXV = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   sum;
    logic             dec;

    assign mark_req = (cnt != '0);
    assign dec      = mark_ack && mark_req;
    assign sum      = {1'b0, cnt} + {{(CNT_W-1){1'b0}}, inc} - {{CNT_W{1'b0}}, dec};

    // Saturating owed-marker count.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= '0;
        else if (sum > (CNT_W+1)'(MAXV))    cnt <= CNT_W'(MAXV);
        else                                cnt <= sum[CNT_W-1:0];
    end

    // R7
    mark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_req && !mark_ack |=> mark_req);
    // R7
    mark_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_ack && (cnt == CNT_W'(1)) && (inc == 2'd0) |=> !mark_req);
endmodule

// File: rtl/trace_evt_ctrl.sv
// Trace flush and trigger event controller. Holds the control word, turns
// pin edges, trigger events and manual writes into serialized flushes,
// owed trigger markers and a sticky formatter stop. Assumes trig_evt,
// ds_flush_req, flush_ack, mark_ack and stop_ack are synchronous pulses.
module trace_evt_ctrl
    import tev_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MCNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             ext_flush_in,
    input  logic             ext_trig_in,
    input  logic             trig_evt,
    input  logic             ds_flush_req,
    output logic             flush_req,
    input  logic             flush_ack,
    output logic             mark_req,
    input  logic             mark_ack,
    output logic [7:0]       mark_data,
    output logic [6:0]       mark_id,
    output logic             fmt_stop,
    input  logic             stop_ack,
    output logic             ready,
    output logic             fmt_on
);
    cfg_t            cfg;
    logic            man_bit;
    logic            cap_q;
    logic            stop_wait;
    logic            stop_busy;
    logic            ext_rise;
    logic            trg_rise;
    logic            done;
    fsrc_e           act_src;
    logic            own_done;
    logic            allowed;
    logic [1:0]      inc;
    logic            stop_set;
    logic            cap_rise;
    logic [NSRC-1:1] set_pulse;

    tev_edge_sync #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk(clk), .rst_n(rst_n), .pin(ext_flush_in), .rise(ext_rise));

    tev_edge_sync #(.STAGES(SYNC_STAGES)) u_tsync (
        .clk(clk), .rst_n(rst_n), .pin(ext_trig_in), .rise(trg_rise));

    assign set_pulse = {ds_flush_req,
                        trig_evt && cfg.fl_tev && !cfg.stop_tev,
                        ext_rise && cfg.fl_ext && !fmt_stop};

    tev_flush_sched u_sched (
        .clk(clk), .rst_n(rst_n), .man_lvl(man_bit), .set_pulse(set_pulse),
        .flush_ack(flush_ack), .flush_req(flush_req), .done(done),
        .act_src(act_src));

    assign own_done = done && (act_src != SRC_DS);
    assign allowed  = cfg.fmt_en | cfg.mk_en;
    assign inc      = allowed ? ({1'b0, own_done && cfg.mk_fl} +
                                 {1'b0, trig_evt && cfg.mk_tev} +
                                 {1'b0, trg_rise && cfg.mk_trg}) : 2'd0;

    tev_mark_cnt #(.CNT_W(MCNT_W)) u_marks (
        .clk(clk), .rst_n(rst_n), .inc(inc), .mark_ack(mark_ack),
        .mark_req(mark_req));

    assign stop_set  = (trig_evt && cfg.stop_tev) || (stop_wait && !mark_req);
    assign cap_rise  = capture_en && !cap_q;
    assign ready     = !stop_busy;
    assign fmt_on    = allowed;
    assign mark_data = MARK_BYTE;
    assign mark_id   = MARK_TID;

    // Control word; the marker enable only moves while idle and not capturing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_we) begin
            cfg.fmt_en   <= cfg_wdata[B_FMT];
            cfg.fl_ext   <= cfg_wdata[B_FEXT];
            cfg.fl_tev   <= cfg_wdata[B_FTEV];
            cfg.mk_fl    <= cfg_wdata[B_MFL];
            cfg.mk_tev   <= cfg_wdata[B_MTEV];
            cfg.mk_trg   <= cfg_wdata[B_MTRG];
            cfg.stop_fl  <= cfg_wdata[B_SFL];
            cfg.stop_tev <= cfg_wdata[B_STEV];
            if (ready && !capture_en) cfg.mk_en <= cfg_wdata[B_MEN];
        end
    end

    // Manual flush bit: set by a write during capture, cleared by its completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      man_bit <= 1'b0;
        else if (cfg_we && cfg_wdata[B_MAN] && capture_en) man_bit <= 1'b1;
        else if (done && act_src == SRC_MAN)             man_bit <= 1'b0;
    end

    // Stop sequencing: wait for owed markers, sticky stop, ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= 1'b0;
            stop_wait <= 1'b0;
            fmt_stop  <= 1'b0;
            stop_busy <= 1'b0;
        end else begin
            cap_q     <= capture_en;
            stop_wait <= (stop_wait && mark_req) || (own_done && cfg.stop_fl);
            if (stop_set)      fmt_stop <= 1'b1;
            else if (cap_rise) fmt_stop <= 1'b0;
            if (stop_set && !fmt_stop) stop_busy <= 1'b1;
            else if (stop_ack)         stop_busy <= 1'b0;
        end
    end

    // R2
    man_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en && !man_bit |=> !man_bit);
    // R6
    stop_tev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_evt && cfg.stop_tev |=> fmt_stop);
    // R11
    rdy_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_stop) |-> !ready);
    // R11
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fmt_stop) |-> $past(capture_en));
    // R10
    men_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready || capture_en) |=> $stable(cfg.mk_en));
    // R9
    ds_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && act_src == SRC_DS && !trig_evt && !stop_wait && !fmt_stop |=> !fmt_stop);
endmodule

// File: tb/tb_trace_evt_ctrl.sv
`timescale 1ns/1ps
module tb_trace_evt_ctrl;
    import tev_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic capture_en = 1'b0, cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic ext_flush_in = 1'b0, ext_trig_in = 1'b0, trig_evt = 1'b0, ds_flush_req = 1'b0;
    logic flush_ack = 1'b0, mark_ack = 1'b0, stop_ack = 1'b0;
    logic flush_req, mark_req, fmt_stop, ready, fmt_on;
    logic [7:0] mark_data;
    logic [6:0] mark_id;

    always #2 clk = ~clk;   // 250 MHz

    trace_evt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .ext_flush_in(ext_flush_in), .ext_trig_in(ext_trig_in),
        .trig_evt(trig_evt), .ds_flush_req(ds_flush_req), .flush_req(flush_req),
        .flush_ack(flush_ack), .mark_req(mark_req), .mark_ack(mark_ack),
        .mark_data(mark_data), .mark_id(mark_id), .fmt_stop(fmt_stop),
        .stop_ack(stop_ack), .ready(ready), .fmt_on(fmt_on));

    int n_chk = 0, n_fail = 0;
    int n_grants = 0, n_marks = 0;
    bit fr_prev = 0, mark_hold = 0, finished = 0, run_model = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [CFG_W-1:0] m_cfg = '0;
    bit m_man = 0, m_act = 0, m_wait = 0, m_stop = 0, m_busy = 0, m_capq = 0;
    bit m_pend[4] = '{0, 0, 0, 0};
    int m_src = 0, m_cnt = 0;
    bit fh[$] = '{0, 0, 0};
    bit th[$] = '{0, 0, 0};

    always @(posedge clk) begin
        bit er, tr, dn, dsd, dman, allow, ss, crise, nwait, nbusy, nstop, men;
        int inc, dec, s, pick;
        if (rst_n) begin
            if (flush_req && !fr_prev) n_grants++;
            if (mark_req && mark_ack) n_marks++;
        end
        fr_prev = flush_req;
        if (!rst_n) begin
            m_cfg = '0; m_man = 0; m_act = 0; m_wait = 0; m_stop = 0; m_busy = 0;
            m_capq = 0; m_src = 0; m_cnt = 0; m_pend = '{0, 0, 0, 0};
            fh = '{0, 0, 0}; th = '{0, 0, 0};
        end else begin
            er = fh[1] && !fh[2];
            tr = th[1] && !th[2];
            dn = m_act && flush_ack;
            dsd = dn && m_src == 3;
            dman = dn && m_src == 0;
            allow = m_cfg[B_FMT] || m_cfg[B_MEN];
            inc = 0;
            if (allow) begin
                if (dn && !dsd && m_cfg[B_MFL]) inc++;
                if (trig_evt && m_cfg[B_MTEV]) inc++;
                if (tr && m_cfg[B_MTRG]) inc++;
            end
            dec = (mark_ack && m_cnt > 0) ? 1 : 0;
            ss = (trig_evt && m_cfg[B_STEV]) || (m_wait && m_cnt == 0);
            crise = capture_en && !m_capq;
            nwait = (m_wait && m_cnt != 0) || (dn && !dsd && m_cfg[B_SFL]);
            nbusy = (ss && !m_stop) ? 1 : (stop_ack ? 0 : m_busy);
            nstop = ss ? 1 : (crise ? 0 : m_stop);
            // flush arbitration (pending flags cleared before new pulses land)
            if (!m_act) begin
                pick = -1;
                if (m_man) pick = 0;
                else for (int i = 1; i < 4; i++) if (m_pend[i] && pick < 0) pick = i;
                if (pick >= 0) begin
                    m_act = 1; m_src = pick;
                    if (pick > 0) m_pend[pick] = 0;
                end
            end else if (flush_ack) m_act = 0;
            if (er && m_cfg[B_FEXT] && !m_stop) m_pend[1] = 1;
            if (trig_evt && m_cfg[B_FTEV] && !m_cfg[B_STEV]) m_pend[2] = 1;
            if (ds_flush_req) m_pend[3] = 1;
            if (cfg_we && cfg_wdata[B_MAN] && capture_en) m_man = 1;
            else if (dman) m_man = 0;
            s = m_cnt + inc - dec;
            m_cnt = (s > 7) ? 7 : s;
            if (cfg_we) begin
                men = m_cfg[B_MEN];
                if (!m_busy && !capture_en) men = cfg_wdata[B_MEN];
                m_cfg = cfg_wdata;
                m_cfg[B_MAN] = 0;
                m_cfg[B_MEN] = men;
            end
            m_wait = nwait; m_busy = nbusy; m_stop = nstop;
            m_capq = capture_en;
            fh.push_front(ext_flush_in); void'(fh.pop_back());
            th.push_front(ext_trig_in);  void'(th.pop_back());
        end
    end

    // Cycle-by-cycle comparison, half a period after the edge.
    always @(negedge clk) begin
        if (run_model && rst_n) begin
            chk("R1 flush_req", int'(flush_req), int'(m_act));
            chk("R8 mark_req", int'(mark_req), (m_cnt != 0) ? 1 : 0);
            chk("R11 fmt_stop", int'(fmt_stop), int'(m_stop));
            chk("R11 ready", int'(ready), m_busy ? 0 : 1);
            chk("R10 fmt_on", int'(fmt_on), (m_cfg[B_FMT] || m_cfg[B_MEN]) ? 1 : 0);
        end
    end

    // ---------------- responders ----------------
    int fa_cnt = 0, sa_cnt = 0;
    always @(negedge clk) begin
        flush_ack = 1'b0;
        if (flush_req) begin
            fa_cnt++;
            if (fa_cnt == 3) begin flush_ack = 1'b1; fa_cnt = 0; end
        end else fa_cnt = 0;
    end
    always @(negedge clk) mark_ack = mark_req && !mark_hold;
    always @(negedge clk) begin
        stop_ack = 1'b0;
        if (rst_n && !ready) begin
            sa_cnt++;
            if (sa_cnt == 3) begin stop_ack = 1'b1; sa_cnt = 0; end
        end else sa_cnt = 0;
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [CFG_W-1:0] bv(int b);
        return CFG_W'(1) << b;
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [CFG_W-1:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pulse_tevt();
        @(negedge clk); trig_evt = 1'b1;
        @(negedge clk); trig_evt = 1'b0;
    endtask

    task automatic pin_flush();
        @(negedge clk); ext_flush_in = 1'b1;
        cyc(4); ext_flush_in = 1'b0;
    endtask

    int g0, k0;

    initial begin
        cyc(4);
        @(negedge clk); rst_n = 1'b1; run_model = 1;
        cyc(1);
        // reset state and marker constants
        chk("R1 reset flush_req", int'(flush_req), 0);
        chk("R11 reset fmt_stop/ready", int'({fmt_stop, ready}), 1);
        chk("R7 mark_data", int'(mark_data), 0);
        chk("R7 mark_id", int'(mark_id), 'h7D);
        chk("R2 reset mark_req", int'(mark_req), 0);

        // R2: manual write ignored while capture is off
        g0 = n_grants;
        wr(bv(B_MAN)); cyc(8);
        chk("R2 manual ignored w/o capture", n_grants - g0, 0);

        // R8: no markers while formatting and marker enable are both clear
        capture_en = 1'b1;
        k0 = n_marks;
        wr(bv(B_MTEV)); pulse_tevt(); cyc(5);
        chk("R8 gated markers", n_marks - k0, 0);

        // R2/R8: manual flush, one marker on completion, self-clear
        g0 = n_grants; k0 = n_marks;
        wr(bv(B_FMT) | bv(B_MFL) | bv(B_MAN)); cyc(20);
        chk("R2 manual flush count", n_grants - g0, 1);
        chk("R8 marker on flush", n_marks - k0, 1);
        cyc(10);
        chk("R2 manual bit cleared", n_grants - g0, 1);

        // R1: four sources at once are serialized
        wr(bv(B_FMT) | bv(B_FEXT) | bv(B_FTEV));
        g0 = n_grants;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = bv(B_FMT) | bv(B_FEXT) | bv(B_FTEV) | bv(B_MAN);
        trig_evt = 1'b1; ds_flush_req = 1'b1; ext_flush_in = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0; trig_evt = 1'b0; ds_flush_req = 1'b0;
        cyc(4); ext_flush_in = 1'b0;
        cyc(40);
        chk("R1 serialized flushes", n_grants - g0, 4);

        // R3: pin edge alone requests a flush
        g0 = n_grants;
        wr(bv(B_FMT) | bv(B_FEXT)); pin_flush(); cyc(15);
        chk("R3 pin flush", n_grants - g0, 1);

        // R8: two markers owed at once, held until released
        k0 = n_marks; mark_hold = 1;
        wr(bv(B_FMT) | bv(B_MTEV) | bv(B_MTRG));
        @(negedge clk); trig_evt = 1'b1; ext_trig_in = 1'b1;
        @(negedge clk); trig_evt = 1'b0;
        cyc(6); ext_trig_in = 1'b0;
        chk("R8 marker held", int'(mark_req), 1);
        mark_hold = 0; cyc(6);
        chk("R8 two markers", n_marks - k0, 2);

        // R9: downstream flush gives no marker and no stop
        g0 = n_grants; k0 = n_marks;
        wr(bv(B_FMT) | bv(B_MFL) | bv(B_SFL));
        @(negedge clk); ds_flush_req = 1'b1;
        @(negedge clk); ds_flush_req = 1'b0;
        cyc(20);
        chk("R9 ds flush ran", n_grants - g0, 1);
        chk("R9 ds no marker", n_marks - k0, 0);
        chk("R9 ds no stop", int'(fmt_stop), 0);

        // R6/R4: stop on trigger event, flush-on-event suppressed
        g0 = n_grants;
        wr(bv(B_FMT) | bv(B_FTEV) | bv(B_STEV));
        pulse_tevt();
        chk("R6 stop next cycle", int'(fmt_stop), 1);
        chk("R11 ready low on stop", int'(ready), 0);
        cyc(10);
        chk("R4 no flush under stop-on-event", n_grants - g0, 0);
        chk("R11 ready after stop_ack", int'(ready), 1);

        // R3: pin edge ignored while stopped
        g0 = n_grants;
        wr(bv(B_FMT) | bv(B_FEXT)); pin_flush(); cyc(10);
        chk("R3 pin ignored when stopped", n_grants - g0, 0);

        // R11: stop sticky until capture rises again
        capture_en = 1'b0; cyc(3);
        chk("R11 stop sticky", int'(fmt_stop), 1);
        capture_en = 1'b1; cyc(2);
        chk("R11 stop cleared by capture", int'(fmt_stop), 0);

        // R10: marker enable forces formatting, locked during capture
        capture_en = 1'b0; cyc(1);
        wr(bv(B_MEN)); cyc(1);
        chk("R10 fmt_on via marker enable", int'(fmt_on), 1);
        capture_en = 1'b1; cyc(1);
        wr('0); cyc(1);
        chk("R10 marker enable locked", int'(fmt_on), 1);

        // R5: stop on flush waits for the flush's marker
        mark_hold = 1;
        wr(bv(B_FMT) | bv(B_MFL) | bv(B_SFL) | bv(B_MAN)); cyc(15);
        chk("R5 stop waits for marker", int'(fmt_stop), 0);
        chk("R5 marker owed", int'(mark_req), 1);
        mark_hold = 0; cyc(5);
        chk("R5 stop after marker", int'(fmt_stop), 1);
        cyc(8);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule